// File: doc/BRIEF.md
# Sector Lock Protection Checker

This block keeps the software lock state of a 1 MB serial flash and decides whether a modify operation may go ahead at a given byte address. The address space is split into 16 sectors of 64 KB. Each sector has one lock register. The lowest sector and the highest sector also have one register for each of their 16 sub-sectors of 4 KB. Each register has two bits. The write-lock bit blocks modification of its region. The lock-down bit freezes that register until the next reset.

A host command decoder issues one operation per cycle using `op_valid` and `op_kind`. The operation is one of: read a lock register, write a lock register, modify one location, erase a sector, or erase the whole array. One cycle later the block returns a response pulse with an allowed flag and, for register reads, the register contents. An active-low pin, `top_guard_n`, makes the top sector read-only while it is held low, whatever its lock bits say. The array itself and the serial framing are not part of this block.

Top module: `seclock_top`

## Requirements
- R1: While `rst_n` is low, and after it is released, every lock bit is 0 and `rsp_valid` is 0. A register that was locked down before the reset accepts writes again afterwards.
- R2: `op_kind` 0 reads a lock register. `rsp_rdata[0]` is the write-lock bit and `rsp_rdata[1]` is the lock-down bit. Bits 7:2 read as 0. `rsp_allowed` is 1. `sub_sel`=1 picks the 4 KB sub-sector register, but only in sector 0 and sector 15; in every other sector `sub_sel` is ignored and the sector register is returned.
- R3: `op_kind` 1 writes `lock_wdata[1:0]` into the register picked as in R2, and bits 7:2 are ignored. When the write is accepted, `rsp_allowed` is 1 and the next operation sees the new value.
- R4: A write to a register whose lock-down bit is already 1 is dropped. It returns `rsp_allowed`=0 and leaves that register unchanged.
- R5: `op_kind` 2 (modify one location) is refused, with `rsp_allowed`=0, when the sector register holding the address has its write-lock bit set.
- R6: In sectors 0 and 15, a modify is also refused when the write-lock bit of the 4 KB sub-sector holding the address is set. That bit has no effect on the other sub-sectors.
- R7: While `top_guard_n` is 0, every modify in sector 15 is refused. While it is 1, sector 15 follows its lock bits like any other sector.
- R8: `op_kind` 3 (sector erase) is refused when the sector register, or any sub-sector register of that sector, has its write-lock bit set. It is also refused when the sector is 15 and `top_guard_n` is 0.
- R9: `op_kind` 4 (bulk erase) is refused when any write-lock bit anywhere is set, or when `top_guard_n` is 0.
- R10: Each cycle with `op_valid`=1 produces exactly one `rsp_valid` pulse on the next cycle. Cycles without an operation produce none. The codes 5 to 7 are answered with `rsp_allowed`=0 and `rsp_rdata`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op_kind | input | 3 | Operation code (0 read, 1 write, 2 modify, 3 sector erase, 4 bulk erase) |
| addr | input | 20 | Byte address of the operation |
| sub_sel | input | 1 | Picks the sub-sector register for lock reads and writes |
| lock_wdata | input | 8 | Lock register write data |
| top_guard_n | input | 1 | Active-low hardware guard for the top sector |
| rsp_valid | output | 1 | Response pulse, one cycle after the operation |
| rsp_allowed | output | 1 | 1 when the operation is permitted or accepted |
| rsp_rdata | output | 8 | Lock register contents for reads, 0 otherwise |

## Verification
Two things can meet in one cycle: a modify or erase query on the top sector, and a change on the guard pin. The bench drives the pin low in the same cycle as such a query, and high again for the next one. It expects a refusal and then an approval, which shows that the pin is sampled in the same cycle as the operation. The other meeting point is a lock write that sets the lock-down bit in the same command that writes the register. The write must still be accepted because the old lock-down bit was 0, and a later write must then be refused. Both cases are judged only through `rsp_allowed` and a read-back of the register.

// File: rtl/seclock_pkg.sv
package seclock_pkg;
    typedef enum logic [2:0] {
        OP_RDLR       = 3'd0,
        OP_WRLR       = 3'd1,
        OP_MODIFY     = 3'd2,
        OP_SECT_ERASE = 3'd3,
        OP_BULK_ERASE = 3'd4
    } op_e;

    localparam int WL_BIT = 0;   // write-lock
    localparam int LD_BIT = 1;   // lock-down
    localparam int LOCK_W = 2;
endpackage

// File: rtl/seclock_bank.sv
module seclock_bank #(
    parameter int NS = 16,   // sectors
    parameter int NB = 16    // sub-sectors per edge sector
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [$clog2(NS)-1:0]         wr_sect,
    input  logic                          wr_sub,
    input  logic                          wr_bank,
    input  logic [$clog2(NB)-1:0]         wr_idx,
    input  logic [seclock_pkg::LOCK_W-1:0] wr_bits,
    output logic [NS-1:0][seclock_pkg::LOCK_W-1:0]          sect_lock,
    output logic [1:0][NB-1:0][seclock_pkg::LOCK_W-1:0]     sub_lock
);
    import seclock_pkg::*;

    typedef struct packed {
        logic [NS-1:0][LOCK_W-1:0]      sect;
        logic [1:0][NB-1:0][LOCK_W-1:0] sub;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (wr_en) begin
            if (wr_sub) bank_d.sub[wr_bank][wr_idx] = wr_bits;
            else        bank_d.sect[wr_sect]        = wr_bits;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    assign sect_lock = bank_q.sect;
    assign sub_lock  = bank_q.sub;

    for (genvar i = 0; i < NS; i++) begin : g_sect_chk
        // R4: a locked-down sector register never changes
        a_r4_sect_frozen: assert property (@(posedge clk) disable iff (!rst_n)
            bank_q.sect[i][LD_BIT] |=> $stable(bank_q.sect[i]));
    end
    for (genvar b = 0; b < 2; b++) begin : g_bank_chk
        for (genvar j = 0; j < NB; j++) begin : g_sub_chk
            // R4: a locked-down sub-sector register never changes
            a_r4_sub_frozen: assert property (@(posedge clk) disable iff (!rst_n)
                bank_q.sub[b][j][LD_BIT] |=> $stable(bank_q.sub[b][j]));
        end
    end
endmodule

// File: rtl/seclock_eval.sv
module seclock_eval #(
    parameter int NS = 16,
    parameter int NB = 16
) (
    input  logic [NS-1:0][seclock_pkg::LOCK_W-1:0]      sect_lock,
    input  logic [1:0][NB-1:0][seclock_pkg::LOCK_W-1:0] sub_lock,
    input  seclock_pkg::op_e                            kind,
    input  logic [$clog2(NS)-1:0]                       sect,
    input  logic [$clog2(NB)-1:0]                       idx,
    input  logic                                        guard_n,
    output logic                                        deny
);
    import seclock_pkg::*;

    logic       is_low, is_top, is_edge, bank;
    logic       any_sect_wl, any_sub_wl, bank_wl_any;
    logic       top_hold;

    always_comb begin
        is_low   = (sect == '0);
        is_top   = (sect == NS[$clog2(NS)-1:0] - 1'b1);
        is_edge  = is_low || is_top;
        bank     = is_top;
        top_hold = is_top && !guard_n;

        any_sect_wl = 1'b0;
        for (int i = 0; i < NS; i++) any_sect_wl |= sect_lock[i][WL_BIT];
        any_sub_wl  = 1'b0;
        bank_wl_any = 1'b0;
        for (int b = 0; b < 2; b++) begin
            for (int j = 0; j < NB; j++) begin
                any_sub_wl |= sub_lock[b][j][WL_BIT];
                if (b == int'(bank)) bank_wl_any |= sub_lock[b][j][WL_BIT];
            end
        end

        unique case (kind)
            OP_MODIFY:     deny = sect_lock[sect][WL_BIT] || top_hold ||
                                  (is_edge && sub_lock[bank][idx][WL_BIT]);
            OP_SECT_ERASE: deny = sect_lock[sect][WL_BIT] || top_hold ||
                                  (is_edge && bank_wl_any);
            OP_BULK_ERASE: deny = any_sect_wl || any_sub_wl || !guard_n;
            default:       deny = 1'b0;
        endcase
    end
endmodule

// File: rtl/seclock_top.sv
module seclock_top #(
    parameter int ADDR_W   = 20,
    parameter int SECT_LSB = 16,
    parameter int SUB_LSB  = 12,
    parameter int DATA_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [2:0]        op_kind,
    input  logic [ADDR_W-1:0] addr,
    input  logic              sub_sel,
    input  logic [DATA_W-1:0] lock_wdata,
    input  logic              top_guard_n,
    output logic              rsp_valid,
    output logic              rsp_allowed,
    output logic [DATA_W-1:0] rsp_rdata
);
    import seclock_pkg::*;

    localparam int SW = ADDR_W - SECT_LSB;
    localparam int BW = SECT_LSB - SUB_LSB;
    localparam int NS = 2 ** SW;
    localparam int NB = 2 ** BW;

    typedef struct packed {
        logic              valid;
        logic              allowed;
        logic [DATA_W-1:0] rdata;
    } rsp_t;

    rsp_t rsp_d, rsp_q;

    logic [NS-1:0][LOCK_W-1:0]      sect_lock;
    logic [1:0][NB-1:0][LOCK_W-1:0] sub_lock;
    logic [SW-1:0]     sect;
    logic [BW-1:0]     idx;
    logic              is_top, use_sub, wr_en, deny;
    logic [LOCK_W-1:0] cur_bits;
    op_e               kind;

    assign kind    = op_e'(op_kind);
    assign sect    = addr[ADDR_W-1:SECT_LSB];
    assign idx     = addr[SECT_LSB-1:SUB_LSB];
    assign is_top  = (sect == SW'(NS - 1));
    assign use_sub = sub_sel && ((sect == '0) || is_top);
    assign cur_bits = use_sub ? sub_lock[is_top][idx] : sect_lock[sect];
    assign wr_en   = op_valid && (kind == OP_WRLR) && !cur_bits[LD_BIT];

    seclock_bank #(.NS(NS), .NB(NB)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_sect   (sect),
        .wr_sub    (use_sub),
        .wr_bank   (is_top),
        .wr_idx    (idx),
        .wr_bits   (lock_wdata[LOCK_W-1:0]),
        .sect_lock (sect_lock),
        .sub_lock  (sub_lock)
    );

    seclock_eval #(.NS(NS), .NB(NB)) u_eval (
        .sect_lock (sect_lock),
        .sub_lock  (sub_lock),
        .kind      (kind),
        .sect      (sect),
        .idx       (idx),
        .guard_n   (top_guard_n),
        .deny      (deny)
    );

    always_comb begin
        rsp_d = '0;
        if (op_valid) begin
            rsp_d.valid = 1'b1;
            unique case (kind)
                OP_RDLR: begin
                    rsp_d.allowed = 1'b1;
                    rsp_d.rdata   = DATA_W'(cur_bits);
                end
                OP_WRLR:                              rsp_d.allowed = !cur_bits[LD_BIT];
                OP_MODIFY, OP_SECT_ERASE, OP_BULK_ERASE: rsp_d.allowed = !deny;
                default:                              rsp_d.allowed = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid   = rsp_q.valid;
    assign rsp_allowed = rsp_q.allowed;
    assign rsp_rdata   = rsp_q.rdata;

    // R10: one response per operation, next cycle
    a_r10_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> rsp_valid);
    a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> !rsp_valid);
    // R7: guard pin low blocks modify in the top sector
    a_r7_guard_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && kind == OP_MODIFY && is_top && !top_guard_n) |=> !rsp_allowed);
    // R9: guard pin low blocks bulk erase
    a_r9_bulk_guard: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && kind == OP_BULK_ERASE && !top_guard_n) |=> !rsp_allowed);
    // R8: sector-level write-lock blocks sector erase
    a_r8_sect_erase_lock: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && kind == OP_SECT_ERASE && sect_lock[sect][WL_BIT]) |=> !rsp_allowed);
    // R2: read data carries only the two lock bits
    a_r2_rdata_upper: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_rdata[DATA_W-1:LOCK_W] == '0));
endmodule

// File: tb/tb_seclock_top.sv
module tb_seclock_top;
    localparam int VW = 46;
    localparam int NV = 31;
    // {req[3:0], kind[2:0], addr[19:0], sub, wdata[7:0], guard_n, exp_allow, exp_rdata[7:0]}
    localparam logic [VW-1:0] VEC [NV] = '{
        {4'd1,  3'd0, 20'h00000, 1'b0, 8'h00, 1'b1, 1'b1, 8'h00}, // R1 read after reset
        {4'd5,  3'd2, 20'h35000, 1'b0, 8'h00, 1'b1, 1'b1, 8'h00}, // R5 unlocked modify
        {4'd9,  3'd4, 20'h00000, 1'b0, 8'h00, 1'b1, 1'b1, 8'h00}, // R9 bulk ok
        {4'd9,  3'd4, 20'h00000, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00}, // R9 bulk, pin low
        {4'd7,  3'd2, 20'hF0000, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00}, // R7 top, pin low
        {4'd7,  3'd2, 20'hF0000, 1'b0, 8'h00, 1'b1, 1'b1, 8'h00}, // R7 top, pin high
        {4'd3,  3'd1, 20'h30000, 1'b0, 8'hFD, 1'b1, 1'b1, 8'h00}, // R3 lock sector 3
        {4'd2,  3'd0, 20'h3ABCD, 1'b1, 8'h00, 1'b1, 1'b1, 8'h01}, // R2 sub_sel ignored
        {4'd5,  3'd2, 20'h3FFFF, 1'b0, 8'h00, 1'b1, 1'b0, 8'h00}, // R5 locked
        {4'd5,  3'd2, 20'h40000, 1'b0, 8'h00, 1'b1, 1'b1, 8'h00}, // R5 neighbour
        {4'd9,  3'd4, 20'h00000, 1'b0, 8'h00, 1'b1, 1'b0, 8'h00}, // R9 any lock
        {4'd3,  3'd1, 20'h30000, 1'b0, 8'h00, 1'b1, 1'b1, 8'h00}, // R3 unlock
        {4'd9,  3'd4, 20'h00000, 1'b0, 8'h00, 1'b1, 1'b1, 8'h00}, // R9 clear again
        {4'd3,  3'd1, 20'h02000, 1'b1, 8'h01, 1'b1, 1'b1, 8'h00}, // R3 lock sub 2 of sect 0
        {4'd6,  3'd2, 20'h02FFF, 1'b0, 8'h00, 1'b1, 1'b0, 8'h00}, // R6 inside sub
        {4'd6,  3'd2, 20'h03000, 1'b0, 8'h00, 1'b1, 1'b1, 8'h00}, // R6 above
        {4'd6,  3'd2, 20'h01FFF, 1'b0, 8'h00, 1'b1, 1'b1, 8'h00}, // R6 below
        {4'd2,  3'd0, 20'h02000, 1'b0, 8'h00, 1'b1, 1'b1, 8'h00}, // R2 sector reg
        {4'd2,  3'd0, 20'h02010, 1'b1, 8'h00, 1'b1, 1'b1, 8'h01}, // R2 sub reg
        {4'd8,  3'd3, 20'h00000, 1'b0, 8'h00, 1'b1, 1'b0, 8'h00}, // R8 sub lock
        {4'd8,  3'd3, 20'h10000, 1'b0, 8'h00, 1'b1, 1'b1, 8'h00}, // R8 other sector
        {4'd4,  3'd1, 20'h02000, 1'b1, 8'h02, 1'b1, 1'b1, 8'h00}, // R4 set lock-down
        {4'd4,  3'd1, 20'h02000, 1'b1, 8'h01, 1'b1, 1'b0, 8'h00}, // R4 write dropped
        {4'd4,  3'd0, 20'h02000, 1'b1, 8'h00, 1'b1, 1'b1, 8'h02}, // R4 unchanged
        {4'd8,  3'd3, 20'h00000, 1'b0, 8'h00, 1'b1, 1'b1, 8'h00}, // R8 now clear
        {4'd3,  3'd1, 20'hF0000, 1'b0, 8'h03, 1'b1, 1'b1, 8'h00}, // R3 lock+freeze top
        {4'd8,  3'd3, 20'hF1234, 1'b0, 8'h00, 1'b1, 1'b0, 8'h00}, // R8 top locked
        {4'd4,  3'd1, 20'hF0000, 1'b0, 8'h00, 1'b1, 1'b0, 8'h00}, // R4 frozen
        {4'd5,  3'd2, 20'h05000, 1'b0, 8'h00, 1'b1, 1'b1, 8'h00}, // R5 unaffected
        {4'd9,  3'd4, 20'h00000, 1'b0, 8'h00, 1'b1, 1'b0, 8'h00}, // R9 top lock
        {4'd10, 3'd7, 20'h00000, 1'b0, 8'h00, 1'b1, 1'b0, 8'h00}  // R10 bad code
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [2:0]  op_kind = '0;
    logic [19:0] addr = '0;
    logic        sub_sel = 1'b0;
    logic [7:0]  lock_wdata = '0;
    logic        top_guard_n = 1'b1;
    logic        rsp_valid, rsp_allowed;
    logic [7:0]  rsp_rdata;
    int          n_chk = 0, n_fail = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    seclock_top dut (.*);

    task automatic check(input string req, input logic [9:0] act, input logic [9:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: {valid,allowed,rdata} actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [2:0] k, input logic [19:0] a, input logic s,
                         input logic [7:0] w, input logic g);
        @(negedge clk);
        op_valid = 1'b1; op_kind = k; addr = a; sub_sel = s; lock_wdata = w; top_guard_n = g;
        @(posedge clk);
        #1;
        op_valid = 1'b0; top_guard_n = 1'b1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1", {rsp_valid, rsp_allowed, rsp_rdata}, 10'h000);
        @(negedge clk) rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            logic [VW-1:0] v;
            v = VEC[i];
            issue(v[41:39], v[38:19], v[18], v[17:10], v[9]);
            check($sformatf("R%0d vec %0d", v[45:42], i),
                  {rsp_valid, rsp_allowed, rsp_rdata}, {1'b1, v[8], v[7:0]});
        end

        // R10: idle cycle yields no response
        @(posedge clk); #1;
        check("R10 idle", {rsp_valid, rsp_allowed, rsp_rdata}, 10'h000);

        // R1: reset clears the locked-down top sector
        @(negedge clk) rst_n = 1'b0;
        #1;
        check("R1 in reset", {rsp_valid, rsp_allowed, rsp_rdata}, 10'h000);
        @(negedge clk) rst_n = 1'b1;
        issue(3'd0, 20'hF0000, 1'b0, 8'h00, 1'b1);
        check("R1 read top", {rsp_valid, rsp_allowed, rsp_rdata}, {2'b11, 8'h00});
        issue(3'd1, 20'hF0000, 1'b0, 8'h02, 1'b1);
        check("R1 write accepted", {rsp_valid, rsp_allowed, rsp_rdata}, {2'b11, 8'h00});
        issue(3'd2, 20'h05000, 1'b0, 8'h00, 1'b1);
        check("R1 sub lock gone", {rsp_valid, rsp_allowed, rsp_rdata}, {2'b11, 8'h00});

        // R6: sub-sector lock in top sector, sector reg clear
        issue(3'd1, 20'hF8000, 1'b1, 8'h01, 1'b1);
        check("R6 top sub write", {rsp_valid, rsp_allowed, rsp_rdata}, {2'b11, 8'h00});
        issue(3'd2, 20'hF8ABC, 1'b0, 8'h00, 1'b1);
        check("R6 top sub locked", {rsp_valid, rsp_allowed, rsp_rdata}, {2'b10, 8'h00});
        issue(3'd2, 20'hF7FFF, 1'b0, 8'h00, 1'b1);
        check("R6 top neighbour", {rsp_valid, rsp_allowed, rsp_rdata}, {2'b11, 8'h00});

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule